// File: doc/BRIEF.md
# Two-Channel Serial Interrupt Vector Arbiter

This block arbitrates the interrupts of a two-channel serial controller. For each channel it keeps a receive-pending flag and a transmit-pending flag, together with a receive in-service flag and a transmit in-service flag. From these flags and the live enable settings it drives one combined interrupt request. It also produces two bytes that the register file presents to software: the interrupt vector and the pending-source summary.

Receive-data and transmit-empty events set the pending flags. A data-register read, or a command written through the control port, clears them. When a source raises its pending flag and its channel has no source of the other type in service, that source takes service and loads the vector. If the other type is already in service, the new source is recorded as pending and leaves the vector alone. The register file, the data paths and the baud logic live outside this block. They supply the enables, the break status, the command byte and the event pulses.

Top module: `sccv_top`

## Requirements
- R1: `irq` is high whenever some channel has its transmit interrupt enable `tx_ie[c]` set and its transmit pending flag set. `irq` is combinational from the registered flags and the current enables.
- R2: A channel's receive pending flag drives `irq` only when that channel's 2-bit receive mode is 01 or 10. Channel A's mode is `rx_mode[1:0]` and channel B's mode is `rx_mode[3:2]`. Modes 00 and 11 never raise `irq` from receive.
- R3: `irq` is high whenever some channel has both `brk_ie[c]` and `brk_stat[c]` set. Break never changes the vector or the pending byte.
- R4: A pulse on `rx_ev[c]` sets that channel's receive pending flag. If no transmit source of the same channel is in service, it also puts receive in service and loads the receive vector of channel c. Channel A is index 0 and channel B is index 1.
- R5: A pulse on `tx_ev[c]` is handled the same way with the roles of receive and transmit swapped. Each channel never has both types in service at once.
- R6: With `status_hi` = 1, the vector is 0x30 for receive A, 0x20 for receive B, 0x10 for transmit A, 0x00 for transmit B and 0x60 for no source.
- R7: With `status_hi` = 0, the vector is 0x0C for receive A, 0x04 for receive B, 0x08 for transmit A, 0x00 for transmit B and 0x06 for no source. The vector byte always follows the current value of `status_hi`.
- R8: `pend_bits` has bit 5 set for receive A pending, bit 4 for transmit A, bit 2 for receive B and bit 1 for transmit B. All other bits are 0.
- R9: Clearing a source clears its pending flag, its in-service flag and its `pend_bits` bit, and sets the vector to "none" (except as R11 states). A pulse on `rx_take[c]` clears receive. A command whose bits 5:3 equal 101 (for example 0x28) clears transmit of channel `cmd_chan`.
- R10: A command whose bits 5:3 equal 111 (for example 0x38) clears the in-service receive source of channel `cmd_chan`. If receive is not in service, it clears the in-service transmit source instead. With neither in service it has no effect. Commands with any other value in bits 5:3 have no effect, and bits 2:0 and 7:6 are ignored.
- R11: When one type is cleared while the other type of the same channel is still pending, the other type goes into service and loads its vector.
- R12: Synchronous active-low reset clears every pending and in-service flag. After reset the vector shows the "none" code for the current `status_hi`.
- R13: Within one cycle, every clear is applied before every set. Channel A is processed before channel B, and the last vector load wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| status_hi | input | 1 | Vector encoding select (1 = high-bit codes) |
| tx_ie | input | 2 | Transmit interrupt enable per channel |
| rx_mode | input | 4 | Receive interrupt mode, A in [1:0], B in [3:2] |
| brk_ie | input | 2 | Break interrupt enable per channel |
| brk_stat | input | 2 | Break status level per channel |
| rx_ev | input | 2 | Receive-data event pulse per channel |
| tx_ev | input | 2 | Transmit-empty event pulse per channel |
| rx_take | input | 2 | Received byte read, clears receive source |
| cmd_valid | input | 1 | Control command strobe |
| cmd_chan | input | 1 | Channel addressed by the command |
| cmd_code | input | 8 | Command byte written to the control port |
| irq | output | 1 | Combined interrupt request |
| vector | output | 8 | Interrupt vector byte |
| pend_bits | output | 8 | Pending-source summary byte |

## Verification
The bench aims at the blocking rule. A receive event that arrives while transmit is in service must record itself as pending without touching the vector. A design that lets it through shows the receive code too early. The bench also checks the hand-over after an in-service clear. A design that omits it leaves a pending source with a "none" vector. Same-cycle clear-and-set and dual-channel events check the ordering: a design that applies sets first loses the fresh receive byte, and one with reversed channel order shows channel A's vector. Unused receive modes 00 and 11, command codes that differ only in ignored bits, and a reset while flags are pending cover the decode and reset corners.

// File: rtl/sccv_pkg.sv
// Shared types and constants for the serial interrupt vector arbiter.
// Assumes two channels, index 0 = channel A, index 1 = channel B.
package sccv_pkg;

    localparam int CH_N   = 2;
    localparam int VEC_W  = 8;
    localparam int MODE_W = 2;

    // Command field (bits 5:3 of the control byte)
    localparam logic [2:0] CMD_TX_CLR  = 3'b101;
    localparam logic [2:0] CMD_IUS_CLR = 3'b111;

    // Receive interrupt modes that request an interrupt
    localparam logic [MODE_W-1:0] RXM_FIRST = 2'b01;
    localparam logic [MODE_W-1:0] RXM_ALL   = 2'b10;

    typedef enum logic [2:0] {
        VK_NONE = 3'd0,
        VK_RXA  = 3'd1,
        VK_RXB  = 3'd2,
        VK_TXA  = 3'd3,
        VK_TXB  = 3'd4
    } vkind_e;

    function automatic vkind_e rx_kind(input logic ch);
        return ch ? VK_RXB : VK_RXA;
    endfunction

    function automatic vkind_e tx_kind(input logic ch);
        return ch ? VK_TXB : VK_TXA;
    endfunction

endpackage

// File: rtl/sccv_chan_req.sv
// Per-channel interrupt request term.
// Combines the enables with the pending flags and the break level.
// Assumes the pending flags are registered upstream.
module sccv_chan_req
    import sccv_pkg::*;
(
    input  logic              tx_ie,
    input  logic [MODE_W-1:0] rx_mode,
    input  logic              brk_ie,
    input  logic              brk_stat,
    input  logic              rx_pend,
    input  logic              tx_pend,
    output logic              req
);

    logic rx_mode_ok;

    // Receive requests only in the two interrupting modes
    always_comb begin
        rx_mode_ok = (rx_mode == RXM_FIRST) || (rx_mode == RXM_ALL);
    end

    // Any one of the three causes raises this channel's request
    always_comb begin
        req = (tx_ie && tx_pend) || (rx_mode_ok && rx_pend) || (brk_ie && brk_stat);
    end

endmodule

// File: rtl/sccv_vec_encode.sv
// Vector byte encoder: maps the stored source kind and the live
// status-high select onto the vector code. Pure combinational.
module sccv_vec_encode
    import sccv_pkg::*;
#(
    parameter int OUT_W = VEC_W
) (
    input  vkind_e           kind,
    input  logic             hi_sel,
    output logic [OUT_W-1:0] vec
);

    // Select the code table for the current encoding mode
    always_comb begin
        if (hi_sel) begin
            unique case (kind)
                VK_RXA:  vec = OUT_W'(8'h30);
                VK_RXB:  vec = OUT_W'(8'h20);
                VK_TXA:  vec = OUT_W'(8'h10);
                VK_TXB:  vec = OUT_W'(8'h00);
                default: vec = OUT_W'(8'h60);
            endcase
        end else begin
            unique case (kind)
                VK_RXA:  vec = OUT_W'(8'h0C);
                VK_RXB:  vec = OUT_W'(8'h04);
                VK_TXA:  vec = OUT_W'(8'h08);
                VK_TXB:  vec = OUT_W'(8'h00);
                default: vec = OUT_W'(8'h06);
            endcase
        end
    end

endmodule

// File: rtl/sccv_arbiter.sv
// Pending / in-service state and vector ownership for all channels.
// One update per clock: clears (A then B), then sets (A then B);
// the last vector load in that order wins. Assumes event inputs are
// single-cycle pulses synchronous to clk.
module sccv_arbiter
    import sccv_pkg::*;
#(
    parameter int NCH = CH_N
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] rx_ev,
    input  logic [NCH-1:0] tx_ev,
    input  logic [NCH-1:0] rx_take,
    input  logic           cmd_valid,
    input  logic           cmd_chan,
    input  logic [7:0]     cmd_code,
    output logic [NCH-1:0] rx_pend,
    output logic [NCH-1:0] tx_pend,
    output vkind_e         kind
);

    logic [NCH-1:0] rxp_q, txp_q, rxs_q, txs_q;
    logic [NCH-1:0] rxp_n, txp_n, rxs_n, txs_n;
    logic [NCH-1:0] clr_rx, clr_tx;
    vkind_e         kind_q, kind_n;
    logic [2:0]     cmd_field;

    assign cmd_field = cmd_code[5:3];

    // Decode which sources each channel clears this cycle
    always_comb begin
        for (int c = 0; c < NCH; c++) begin
            clr_rx[c] = rx_take[c] ||
                        (cmd_valid && (cmd_chan == 1'(c)) &&
                         (cmd_field == CMD_IUS_CLR) && rxs_q[c]);
            clr_tx[c] = (cmd_valid && (cmd_chan == 1'(c)) &&
                         (cmd_field == CMD_TX_CLR)) ||
                        (cmd_valid && (cmd_chan == 1'(c)) &&
                         (cmd_field == CMD_IUS_CLR) && !rxs_q[c] && txs_q[c]);
        end
    end

    // Next-state: ordered clears, hand-over, then ordered sets
    always_comb begin
        rxp_n  = rxp_q;
        txp_n  = txp_q;
        rxs_n  = rxs_q;
        txs_n  = txs_q;
        kind_n = kind_q;
        for (int c = 0; c < NCH; c++) begin
            if (clr_rx[c]) begin
                rxp_n[c] = 1'b0;
                rxs_n[c] = 1'b0;
                kind_n   = VK_NONE;
                if (txp_n[c]) begin
                    txs_n[c] = 1'b1;
                    kind_n   = tx_kind(1'(c));
                end
            end
            if (clr_tx[c]) begin
                txp_n[c] = 1'b0;
                txs_n[c] = 1'b0;
                kind_n   = VK_NONE;
                if (rxp_n[c]) begin
                    rxs_n[c] = 1'b1;
                    kind_n   = rx_kind(1'(c));
                end
            end
        end
        for (int c = 0; c < NCH; c++) begin
            if (rx_ev[c]) begin
                rxp_n[c] = 1'b1;
                if (!txs_n[c]) begin
                    rxs_n[c] = 1'b1;
                    kind_n   = rx_kind(1'(c));
                end
            end
            if (tx_ev[c]) begin
                txp_n[c] = 1'b1;
                if (!rxs_n[c]) begin
                    txs_n[c] = 1'b1;
                    kind_n   = tx_kind(1'(c));
                end
            end
        end
    end

    // State register with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rxp_q  <= '0;
            txp_q  <= '0;
            rxs_q  <= '0;
            txs_q  <= '0;
            kind_q <= VK_NONE;
        end else begin
            rxp_q  <= rxp_n;
            txp_q  <= txp_n;
            rxs_q  <= rxs_n;
            txs_q  <= txs_n;
            kind_q <= kind_n;
        end
    end

    assign rx_pend = rxp_q;
    assign tx_pend = txp_q;
    assign kind    = kind_q;

    // Per-channel checks on the stored flags
    for (genvar g = 0; g < NCH; g++) begin : g_chk
        // R5: one type in service per channel
        a_r5_ius_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
            !(rxs_q[g] && txs_q[g]));
        // R9: an in-service source is always pending
        a_r9_svc_implies_pend: assert property (@(posedge clk) disable iff (!rst_n)
            (rxs_q[g] |-> rxp_q[g]) and (txs_q[g] |-> txp_q[g]));
        // R9: transmit clear command drops transmit pending
        a_r9_tx_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_valid && (cmd_chan == 1'(g)) && (cmd_code[5:3] == CMD_TX_CLR) && !tx_ev[g])
            |=> !txp_q[g]);
        // R4: receive event with no transmit pending takes service
        a_r4_rx_takes_svc: assert property (@(posedge clk) disable iff (!rst_n)
            (rx_ev[g] && !txp_q[g]) |=> (rxs_q[g] && rxp_q[g]));
    end

endmodule

// File: rtl/sccv_top.sv
// Serial interrupt vector arbiter top: state, per-channel request
// terms, vector encoding and pending-byte assembly.
// Assumes channel A is index 0 and channel B is index 1.
module sccv_top
    import sccv_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        status_hi,
    input  logic [1:0]  tx_ie,
    input  logic [3:0]  rx_mode,
    input  logic [1:0]  brk_ie,
    input  logic [1:0]  brk_stat,
    input  logic [1:0]  rx_ev,
    input  logic [1:0]  tx_ev,
    input  logic [1:0]  rx_take,
    input  logic        cmd_valid,
    input  logic        cmd_chan,
    input  logic [7:0]  cmd_code,
    output logic        irq,
    output logic [7:0]  vector,
    output logic [7:0]  pend_bits
);

    logic [CH_N-1:0] rx_pend, tx_pend, ch_req;
    vkind_e          kind;

    sccv_arbiter #(.NCH(CH_N)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_ev     (rx_ev),
        .tx_ev     (tx_ev),
        .rx_take   (rx_take),
        .cmd_valid (cmd_valid),
        .cmd_chan  (cmd_chan),
        .cmd_code  (cmd_code),
        .rx_pend   (rx_pend),
        .tx_pend   (tx_pend),
        .kind      (kind)
    );

    for (genvar g = 0; g < CH_N; g++) begin : g_req
        sccv_chan_req u_req (
            .tx_ie    (tx_ie[g]),
            .rx_mode  (rx_mode[g*MODE_W +: MODE_W]),
            .brk_ie   (brk_ie[g]),
            .brk_stat (brk_stat[g]),
            .rx_pend  (rx_pend[g]),
            .tx_pend  (tx_pend[g]),
            .req      (ch_req[g])
        );
        // R1: an enabled transmit pending source must reach irq
        a_r1_tx_reaches_irq: assert property (@(posedge clk) disable iff (!rst_n)
            (tx_ie[g] && tx_pend[g]) |-> irq);
    end

    sccv_vec_encode #(.OUT_W(VEC_W)) u_enc (
        .kind   (kind),
        .hi_sel (status_hi),
        .vec    (vector)
    );

    // Combined request is the OR of all channel terms
    always_comb begin
        irq = |ch_req;
    end

    // Pending summary byte at fixed bit positions
    always_comb begin
        pend_bits = {2'b00, rx_pend[0], tx_pend[0], 1'b0, rx_pend[1], tx_pend[1], 1'b0};
    end

endmodule

// File: tb/tb_sccv_top.sv
`timescale 1ns/1ps
module tb_sccv_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       status_hi = 1'b0;
    logic [1:0] tx_ie = '0, brk_ie = '0, brk_stat = '0;
    logic [3:0] rx_mode = '0;
    logic [1:0] rx_ev = '0, tx_ev = '0, rx_take = '0;
    logic       cmd_valid = 1'b0, cmd_chan = 1'b0;
    logic [7:0] cmd_code = '0;
    logic       irq;
    logic [7:0] vector, pend_bits;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // Reference model state
    bit m_rxp[2], m_txp[2], m_rxs[2], m_txs[2];
    int m_kind; // 0 none, 1 rxA, 2 rxB, 3 txA, 4 txB

    always #2.5 clk = ~clk;

    sccv_top dut (
        .clk(clk), .rst_n(rst_n), .status_hi(status_hi), .tx_ie(tx_ie),
        .rx_mode(rx_mode), .brk_ie(brk_ie), .brk_stat(brk_stat),
        .rx_ev(rx_ev), .tx_ev(tx_ev), .rx_take(rx_take),
        .cmd_valid(cmd_valid), .cmd_chan(cmd_chan), .cmd_code(cmd_code),
        .irq(irq), .vector(vector), .pend_bits(pend_bits)
    );

    function automatic logic [7:0] exp_vec(int k, bit hi);
        if (hi) begin
            case (k) 1: return 8'h30; 2: return 8'h20; 3: return 8'h10; 4: return 8'h00; default: return 8'h60; endcase
        end
        case (k) 1: return 8'h0C; 2: return 8'h04; 3: return 8'h08; 4: return 8'h00; default: return 8'h06; endcase
    endfunction

    function automatic logic [7:0] exp_pend();
        logic [7:0] p = 8'h00;
        if (m_rxp[0]) p = p | 8'h20;
        if (m_txp[0]) p = p | 8'h10;
        if (m_rxp[1]) p = p | 8'h04;
        if (m_txp[1]) p = p | 8'h02;
        return p;
    endfunction

    function automatic bit exp_irq();
        bit r = 0;
        for (int c = 0; c < 2; c++) begin
            int md = int'(rx_mode[2*c +: 2]);
            if (tx_ie[c] && m_txp[c]) r = 1;
            if ((md == 1 || md == 2) && m_rxp[c]) r = 1;
            if (brk_ie[c] && brk_stat[c]) r = 1;
        end
        return r;
    endfunction

    task automatic model_step();
        bit drx[2], dtx[2];
        if (!rst_n) begin
            for (int c = 0; c < 2; c++) begin
                m_rxp[c] = 0; m_txp[c] = 0; m_rxs[c] = 0; m_txs[c] = 0;
            end
            m_kind = 0;
            return;
        end
        for (int c = 0; c < 2; c++) begin
            bit hit = cmd_valid && (int'(cmd_chan) == c);
            int f = int'(cmd_code[5:3]);
            drx[c] = rx_take[c] || (hit && f == 7 && m_rxs[c]);
            dtx[c] = (hit && f == 5) || (hit && f == 7 && !m_rxs[c] && m_txs[c]);
        end
        for (int c = 0; c < 2; c++) begin
            if (drx[c]) begin
                m_rxp[c] = 0; m_rxs[c] = 0; m_kind = 0;
                if (m_txp[c]) begin m_txs[c] = 1; m_kind = 3 + c; end
            end
            if (dtx[c]) begin
                m_txp[c] = 0; m_txs[c] = 0; m_kind = 0;
                if (m_rxp[c]) begin m_rxs[c] = 1; m_kind = 1 + c; end
            end
        end
        for (int c = 0; c < 2; c++) begin
            if (rx_ev[c]) begin
                m_rxp[c] = 1;
                if (!m_txs[c]) begin m_rxs[c] = 1; m_kind = 1 + c; end
            end
            if (tx_ev[c]) begin
                m_txp[c] = 1;
                if (!m_rxs[c]) begin m_txs[c] = 1; m_kind = 3 + c; end
            end
        end
    endtask

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock: model follows the edge, outputs compared at the falling edge
    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        chk("R6 R7 vector vs model", vector, exp_vec(m_kind, status_hi));
        chk("R8 pend_bits vs model", pend_bits, exp_pend());
        chk("R1 R2 R3 irq vs model", {7'd0, irq}, {7'd0, exp_irq()});
    endtask

    task automatic clear_pulses();
        rx_ev = '0; tx_ev = '0; rx_take = '0; cmd_valid = 0; cmd_code = '0; cmd_chan = 0;
    endtask

    task automatic cmd(bit ch, logic [7:0] code);
        cmd_valid = 1; cmd_chan = ch; cmd_code = code;
        tick();
        clear_pulses();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        m_kind = 0;
        repeat (3) tick();
        rst_n = 1;
        tick();
        // R12: reset state
        chk("R12 vector after reset", vector, 8'h06);
        chk("R12 pend after reset", pend_bits, 8'h00);
        chk("R12 irq after reset", {7'd0, irq}, 8'h00);
        // R7: vector follows select
        status_hi = 1; tick();
        chk("R7 none code hi", vector, 8'h60);
        // R4 R6 R2: receive A in mode 01
        rx_mode = 4'b0001; rx_ev = 2'b01; tick(); clear_pulses();
        chk("R4 R6 rx A vector", vector, 8'h30);
        chk("R8 rx A pend bit", pend_bits, 8'h20);
        chk("R2 irq mode 01", {7'd0, irq}, 8'h01);
        rx_mode = 4'b0011; tick();
        chk("R2 irq mode 11", {7'd0, irq}, 8'h00);
        rx_mode = 4'b0000; tick();
        chk("R2 irq mode 00", {7'd0, irq}, 8'h00);
        rx_mode = 4'b0010; tick();
        chk("R2 irq mode 10", {7'd0, irq}, 8'h01);
        // R5: transmit A blocked by receive A in service
        tx_ev = 2'b01; tick(); clear_pulses();
        chk("R5 tx blocked vector", vector, 8'h30);
        chk("R8 both A pend", pend_bits, 8'h30);
        // R11: receive taken, transmit takes over
        rx_take = 2'b01; tick(); clear_pulses();
        chk("R11 tx A takes vector", vector, 8'h10);
        chk("R11 pend after take", pend_bits, 8'h10);
        chk("R1 irq tx_ie off", {7'd0, irq}, 8'h00);
        tx_ie = 2'b01; tick();
        chk("R1 irq tx_ie on", {7'd0, irq}, 8'h01);
        // R9: transmit clear command
        cmd(1'b0, 8'h28);
        chk("R9 tx clear pend", pend_bits, 8'h00);
        chk("R9 tx clear vector", vector, 8'h60);
        // R6 R7: transmit B code in both encodings
        tx_ie = 2'b10; tx_ev = 2'b10; tick(); clear_pulses();
        chk("R6 tx B vector hi", vector, 8'h00);
        chk("R8 tx B pend", pend_bits, 8'h02);
        status_hi = 0; tick();
        chk("R7 tx B vector lo", vector, 8'h00);
        // R5: receive B blocked by transmit B in service
        rx_ev = 2'b10; tick(); clear_pulses();
        chk("R5 rx B blocked vector", vector, 8'h00);
        chk("R8 B both pend", pend_bits, 8'h06);
        // R10 R11: in-service clear picks transmit, receive takes over
        cmd(1'b1, 8'h38);
        chk("R10 ius clear tx B vector", vector, 8'h04);
        chk("R11 rx B pend left", pend_bits, 8'h04);
        cmd(1'b1, 8'h38);
        chk("R10 ius clear rx B vector", vector, 8'h06);
        chk("R10 ius clear rx B pend", pend_bits, 8'h00);
        // R10: no-effect cases
        rx_ev = 2'b01; tick(); clear_pulses();
        chk("R7 rx A lo vector", vector, 8'h0C);
        cmd(1'b1, 8'h38);
        chk("R10 ius clear idle chan", vector, 8'h0C);
        cmd(1'b0, 8'h30);
        chk("R10 other code ignored", pend_bits, 8'h20);
        cmd(1'b0, 8'h3F);
        chk("R10 low bits ignored vector", vector, 8'h06);
        chk("R10 low bits ignored pend", pend_bits, 8'h00);
        // R3: break term
        tx_ie = '0; rx_mode = '0; brk_ie = 2'b01; brk_stat = 2'b00; tick();
        chk("R3 break enable only", {7'd0, irq}, 8'h00);
        brk_stat = 2'b01; tick();
        chk("R3 break A", {7'd0, irq}, 8'h01);
        chk("R3 break no vector", vector, 8'h06);
        brk_ie = 2'b00; tick();
        chk("R3 break disabled", {7'd0, irq}, 8'h00);
        brk_ie = 2'b10; brk_stat = 2'b10; tick();
        chk("R3 break B", {7'd0, irq}, 8'h01);
        brk_ie = '0; brk_stat = '0;
        // R13: ordering within a cycle
        rx_ev = 2'b11; tick(); clear_pulses();
        chk("R13 B loads last", vector, 8'h04);
        chk("R13 both rx pend", pend_bits, 8'h24);
        rx_take = 2'b01; rx_ev = 2'b01; tick(); clear_pulses();
        chk("R13 clear before set pend", pend_bits, 8'h24);
        chk("R13 clear before set vector", vector, 8'h0C);
        rx_take = 2'b11; tick(); clear_pulses();
        chk("R9 both taken", pend_bits, 8'h00);
        // Random traffic against the model
        for (int i = 0; i < 3000; i++) begin
            int sel = $urandom_range(0, 7);
            status_hi = 1'($urandom);
            tx_ie = 2'($urandom); rx_mode = 4'($urandom);
            brk_ie = 2'($urandom); brk_stat = 2'($urandom);
            rx_ev = 2'($urandom) & 2'($urandom);
            tx_ev = 2'($urandom) & 2'($urandom);
            rx_take = 2'($urandom) & 2'($urandom) & 2'($urandom);
            cmd_valid = (sel < 3);
            cmd_chan = 1'($urandom);
            cmd_code = (sel == 0) ? 8'h28 : (sel == 1) ? 8'h38 : 8'($urandom);
            tick();
        end
        clear_pulses();
        tx_ie = '0; rx_mode = '0; brk_ie = '0; brk_stat = '0;
        // R12: reset with everything pending
        rx_ev = 2'b11; tx_ev = 2'b11; tick(); clear_pulses();
        rst_n = 0; tick(); rst_n = 1; tick();
        chk("R12 pend cleared by reset", pend_bits, 8'h00);
        chk("R12 vector none after reset", vector, exp_vec(0, status_hi));
        chk("R12 irq low after reset", {7'd0, irq}, 8'h00);
        finish_run();
    end

endmodule